// File: doc/BRIEF.md
# Three-Leg Dead-Time Square-Wave Generator

This block drives the six switches of a three-leg bridge from one system clock. A single counter sets the period. Three square-wave phase commands are taken from that counter, with the second and third phases shifted by one third and two thirds of the period. Each command is close to 50 percent duty. Each leg turns its command into a high-side gate enable, which follows the command, and a low-side gate enable, which follows its inverse.

Dead time comes from delaying only the turn-on of each gate. A gate goes high a programmed number of cycles after its own command rises, and it drops in the same cycle its command falls. There is no feedback and no duty modulation. The controller sets the period count (about 2128 gives 47 kHz from a 100 MHz clock) and the dead-time count, then raises the enable.

Top module: `tri_leg_pwm`

## Requirements
- R1: While rst_n is low, all six gate outputs are low. At the first rising clock edge that samples en low, all six outputs go low and stay low while en stays low.
- R2: The first rising edge that samples en high begins period cycle 0. Cycles are numbered 0 to P-1 within a period, and the outputs show the state of cycle k one clock edge later. Leg n (n = 0, 1, 2; gate bit n) has a command that is high when ((k - floor(n*P/3)) mod P) < floor(P/2).
- R3: In each leg, gate_hi[n] follows that leg's command and gate_lo[n] follows its inverse. With a dead-time count of 0 this gives complementary square waves in which the high phase lasts floor(P/2) cycles.
- R4: A gate output goes high only after its own command has been high for D consecutive earlier cycles, where D is the dead-time count. It goes low one edge after the command falls, with no extra delay.
- R5: gate_hi[n] and gate_lo[n] are never high in the same cycle.
- R6: period_in and dead_in are sampled only at the start edge and at the edge that leaves cycle P-1. A change made in the middle of a period first takes effect in the next period.
- R7: When the dead-time count D is at least floor(P/2), all six outputs stay low for that period.
- R8: A period count below 3 is treated as 3.
- R9: Period counts up to 2^CNT_W-1 are honoured, for example 2128 for about 47 kHz at 100 MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; when low, the outputs are off and the counter is cleared |
| period_in | input | CNT_W | Period length in clock cycles |
| dead_in | input | CNT_W | Turn-on delay in clock cycles |
| gate_hi | output | 3 | High-side gate enables, bit n for leg n |
| gate_lo | output | 3 | Low-side gate enables, bit n for leg n |

## Verification
A period boundary can fall in the same cycle as a pending change to the period or dead-time count. The bench provokes this by changing the inputs in the middle of a period and checking that the old timing holds to the wrap and the new timing starts right after it. One test changes the dead time to an excessive value, so the boundary also switches the outputs to all-low. Turn-off of one gate and the delayed turn-on of its partner meet in every cycle. Every sampled cycle is therefore compared against a cycle-by-cycle reference, and any overlap within a leg is flagged.

// File: rtl/tlp_pkg.sv
`timescale 1ns/1ps
package tlp_pkg;
  localparam int unsigned MIN_PERIOD = 3;

  // period actually used for a requested count
  function automatic int unsigned eff_period(int unsigned req);
    return (req < MIN_PERIOD) ? MIN_PERIOD : req;
  endfunction

  // start cycle of a leg's high window
  function automatic int unsigned leg_shift(int unsigned per, int unsigned idx);
    return (idx * per) / 3;
  endfunction

  // leg command level at counter position pos
  function automatic logic leg_phase(int unsigned pos, int unsigned per, int unsigned shift);
    int unsigned rel;
    rel = (pos >= shift) ? (pos - shift) : (pos + per - shift);
    return rel < (per / 2);
  endfunction

  // dead time that would swallow a whole half period
  function automatic logic dead_too_long(int unsigned dead, int unsigned per);
    return dead >= (per / 2);
  endfunction
endpackage

// File: rtl/tlp_timebase.sv
`timescale 1ns/1ps
module tlp_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] dead_in,
  output logic             running,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] dead_q,
  output logic             at_wrap
);
  import tlp_pkg::*;

  logic [CNT_W-1:0] per_next;
  assign per_next = CNT_W'(eff_period(32'(period_in)));
  assign at_wrap  = running && (cnt == per_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      per_q   <= CNT_W'(MIN_PERIOD);
      dead_q  <= '0;
    end else if (!en) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!running || at_wrap) begin
      running <= 1'b1;
      cnt     <= '0;
      per_q   <= per_next;
      dead_q  <= dead_in;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R6
  settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && en && !at_wrap) |=> ($stable(per_q) && $stable(dead_q)));

  // R8
  min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (per_q >= CNT_W'(MIN_PERIOD)));
endmodule

// File: rtl/tlp_turnon_delay.sv
`timescale 1ns/1ps
module tlp_turnon_delay #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cmd,
  input  logic [CNT_W-1:0] dead,
  output logic             gate_q
);
  localparam logic [CNT_W-1:0] RUN_MAX = '1;

  logic             live;
  logic [CNT_W-1:0] run;
  logic             ripe;

  assign live = en && cmd;
  assign ripe = run >= dead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= '0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= live && ripe;
      if (!live)               run <= '0;
      else if (run != RUN_MAX) run <= run + CNT_W'(1);
    end
  end

  // R4
  fast_turnoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd |=> !gate_q);
endmodule

// File: rtl/tlp_leg.sv
`timescale 1ns/1ps
module tlp_leg #(
  parameter int CNT_W   = 16,
  parameter int LEG_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             running,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] per_q,
  input  logic [CNT_W-1:0] dead_q,
  output logic             gate_hi,
  output logic             gate_lo
);
  import tlp_pkg::*;

  logic phase;
  logic excess;
  logic [1:0] side_cmd;
  logic [1:0] side_gate;

  assign phase  = leg_phase(32'(cnt), 32'(per_q), leg_shift(32'(per_q), LEG_IDX));
  assign excess = dead_too_long(32'(dead_q), 32'(per_q));
  assign side_cmd[0] = running && !excess && phase;
  assign side_cmd[1] = running && !excess && !phase;

  for (genvar s = 0; s < 2; s++) begin : g_side
    tlp_turnon_delay #(.CNT_W(CNT_W)) u_dly (
      .clk(clk), .rst_n(rst_n), .en(en),
      .cmd(side_cmd[s]), .dead(dead_q), .gate_q(side_gate[s])
    );
  end

  assign gate_hi = side_gate[0];
  assign gate_lo = side_gate[1];

  // R5
  no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  // R7
  excess_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && excess) |=> (!gate_hi && !gate_lo));
endmodule

// File: rtl/tri_leg_pwm.sv
`timescale 1ns/1ps
module tri_leg_pwm #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] dead_in,
  output logic [2:0]       gate_hi,
  output logic [2:0]       gate_lo
);
  localparam int LEGS = 3;

  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] dead_q;
  logic             at_wrap;

  tlp_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(en),
    .period_in(period_in), .dead_in(dead_in),
    .running(running), .cnt(cnt), .per_q(per_q), .dead_q(dead_q),
    .at_wrap(at_wrap)
  );

  for (genvar n = 0; n < LEGS; n++) begin : g_leg
    tlp_leg #(.CNT_W(CNT_W), .LEG_IDX(n)) u_leg (
      .clk(clk), .rst_n(rst_n), .en(en), .running(running),
      .cnt(cnt), .per_q(per_q), .dead_q(dead_q),
      .gate_hi(gate_hi[n]), .gate_lo(gate_lo[n])
    );
  end

  // R1
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((gate_hi == 3'b000) && (gate_lo == 3'b000)));
endmodule

// File: tb/tri_leg_pwm_test.sv
`timescale 1ns/1ps
module tri_leg_pwm_test;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [CNT_W-1:0] period_in = '0;
  logic [CNT_W-1:0] dead_in = '0;
  logic [2:0] gate_hi;
  logic [2:0] gate_lo;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string cur_tag = "R1";
  logic [5:0] exq[$];

  always #5 clk = ~clk;

  tri_leg_pwm #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .period_in(period_in), .dead_in(dead_in),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got hi/lo %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pop one expected item per sampled cycle
  always @(negedge clk) begin
    if (exq.size() > 0) begin
      logic [5:0] e;
      e = exq.pop_front();
      check(cur_tag, {gate_hi, gate_lo}, e);
    end
    if (rst_n && ((gate_hi & gate_lo) != 3'b000)) begin
      n_tests++;
      n_fail++;
      $display("FAIL R5: overlap hi %b lo %b expected none", gate_hi, gate_lo);
    end
  end

  function automatic int clampp(int p);
    if (p < 3) return 3;
    return p;
  endfunction

  // driver: runs n cycles, switches settings during cycle c, drops enable at the end
  task automatic run_seg(input string tag, input int p1, input int d1,
                         input int p2, input int d2, input int c, input int n);
    int mp, md, pos;
    int hr[3];
    int lr[3];
    @(negedge clk);
    cur_tag = tag;
    period_in = CNT_W'(p1);
    dead_in = CNT_W'(d1);
    en = 1'b1;
    @(posedge clk);
    #1;
    mp = clampp(p1);
    md = d1;
    pos = 0;
    for (int i = 0; i < 3; i++) begin hr[i] = 0; lr[i] = 0; end
    exq.push_back(6'b0);
    for (int k = 0; k < n - 1; k++) begin
      logic [2:0] eh, el;
      bit swallow;
      swallow = (md >= mp / 2);
      for (int i = 0; i < 3; i++) begin
        int rel;
        bit ph, hc, lc;
        rel = (pos + mp - (i * mp) / 3) % mp;
        ph = (rel < mp / 2);
        hc = ph && !swallow;
        lc = !ph && !swallow;
        eh[i] = hc && (hr[i] >= md);
        el[i] = lc && (lr[i] >= md);
        hr[i] = hc ? hr[i] + 1 : 0;
        lr[i] = lc ? lr[i] + 1 : 0;
      end
      exq.push_back({eh, el});
      if (pos == mp - 1) begin
        pos = 0;
        if (k >= c) begin mp = clampp(p2); md = d2; end
      end else begin
        pos++;
      end
    end
    exq.push_back(6'b0);
    repeat (c + 1) @(negedge clk);
    period_in = CNT_W'(p2);
    dead_in = CNT_W'(d2);
    repeat (n - 1 - c) @(negedge clk);
    en = 1'b0;
    wait (exq.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {gate_hi, gate_lo}, 6'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle", {gate_hi, gate_lo}, 6'b0);
    run_seg("R2 R3 R4 P12 D2", 12, 2, 12, 2, 40, 50);
    run_seg("R3 odd P13 D0", 13, 0, 13, 0, 40, 45);
    run_seg("R6 mid-period change", 20, 3, 15, 1, 7, 80);
    run_seg("R6 dead raised to excess", 10, 1, 10, 5, 3, 40);
    run_seg("R7 dead at half", 12, 6, 12, 6, 20, 30);
    run_seg("R4 R7 dead just under half", 12, 5, 12, 5, 20, 30);
    run_seg("R8 period 1", 1, 0, 0, 0, 4, 20);
    run_seg("R9 R1 long period", 2128, 20, 2128, 20, 10, 4300);
    check("R1 after runs", {gate_hi, gate_lo}, 6'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule